// File: doc/BRIEF.md
# Seconds-Resolution Watchdog Timer

This block is a watchdog whose single 8-bit count register serves as the start, stop and time-left interface. Software first writes a register index through an index strobe, then reads or writes that register through a data strobe. Writing a nonzero value to the count register arms the watchdog with that many time units. Writing zero stops it. Reading the register returns the units still left. A prescaler derives one-second ticks from the system clock. An optional minute mode stretches each unit to sixty seconds.

When the count runs down to zero, the block drives an active-low watchdog output pulse of fixed length and latches a timeout flag. If enabled, it also drives the same pulse on an active-low keyboard-reset output. Activity pulses from the keyboard or mouse can reload the count with the last armed value. Each source has its own enable. A parameter selects between two index layouts for the count and control registers.

Top module: `wdt_sec_top`

## Requirements
- R1: After reset the count is 0, the timeout flag is 0, both active-low outputs are high, and every register reads 0. The index register resets to 0x00, which is unmapped.
- R2: Writing a nonzero value N to the count register loads N, restarts the prescaler and starts the countdown. The readback falls by one every CLKS_PER_SEC clocks. The first decrement lands on the clock edge CLKS_PER_SEC edges after the write edge.
- R3: Writing 0 to the count register stops the countdown at once. The count then stays 0, no pulse is issued, and activity inputs do not reload it.
- R4: The count reaches 0 on the edge N*CLKS_PER_SEC edges after the write of N. From that edge, watchdog output `wdtOutN` is low for exactly PULSE_CLKS clocks.
- R5: Control bit 1 set to 1 makes `kbdRstN` pulse low together with `wdtOutN`. With the bit at 0, `kbdRstN` stays high.
- R6: Expiry sets the timeout flag, read as bit 4 of the status register (index 0xF7). Writing that bit as 0 clears the flag, and writing it as 1 leaves the flag unchanged.
- R7: Control bit 3 set to 1 selects minute units, so one count lasts 60*CLKS_PER_SEC clocks.
- R8: While the watchdog runs, a one-clock pulse on `kbdAct` reloads the count with the last nonzero value written and restarts the prescaler. This happens only when control bit 2 or status bit 6 is 1. Otherwise the pulse is ignored.
- R9: While the watchdog runs and status bit 7 is 1, a one-clock pulse on `mouseAct` reloads the count the same way. With the bit at 0, the pulse is ignored.
- R10: A count-register write in the same cycle as a unit tick wins. The count takes the written value, not the decremented one.
- R11: With ALT_LAYOUT=0 the count register is at index 0xF6 and the control register at 0xF5. With ALT_LAYOUT=1 they are at 0xF4 and 0xF3. The status register is at 0xF7 in both layouts. Control reads back only bits 3:1. Unmapped indices read 0 and ignore writes.
- R12: Rewriting a nonzero count while running restarts the countdown from the new value, with a full unit before the next decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idxWr | input | 1 | Strobe: capture `wrData` as register index |
| dataWr | input | 1 | Strobe: write `wrData` to the indexed register |
| wrData | input | 8 | Index or data byte |
| rdData | output | 8 | Contents of the indexed register |
| kbdAct | input | 1 | One-clock keyboard activity pulse |
| mouseAct | input | 1 | One-clock mouse activity pulse |
| wdtOutN | output | 1 | Active-low watchdog expiry pulse |
| kbdRstN | output | 1 | Active-low keyboard-reset pulse |

## Verification
The countdown is tried with short second-mode counts, where readback is sampled on both sides of every decrement edge and the expiry edge. This separates an off-by-one prescaler from a correct one, and a pulse that is one clock too short or too long from an exact one. A minute-mode count shows whether the sixty-second divider sits in the tick path. Activity pulses are applied with each enable on and off, so a reload path that ignores its enable is exposed by an unchanged count. A data write placed on the exact tick edge, and a second instance in the alternate layout, cover priority and index decoding.

// File: rtl/wdt_sec_pkg.sv
package wdt_sec_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STS   = 2'd3
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadCount;
    logic [CNT_W-1:0] loadVal;
    logic             reload;
    logic             unitTick;
    logic             clrFlag;
    logic             kbdRstEn;
  } wdtStb_t;

  localparam logic [7:0] IDX_STS = 8'hF7;

  function automatic logic [7:0] countIdx(input bit alt);
    return alt ? 8'hF4 : 8'hF6;
  endfunction

  function automatic logic [7:0] ctrlIdx(input bit alt);
    return alt ? 8'hF3 : 8'hF5;
  endfunction

endpackage

// File: rtl/wdt_sec_ctrl.sv
module wdt_sec_ctrl
  import wdt_sec_pkg::*;
#(
  parameter int CLKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN = 60,
  parameter bit ALT_LAYOUT   = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWr,
  input  logic       dataWr,
  input  logic [7:0] wrData,
  input  logic       kbdAct,
  input  logic       mouseAct,
  input  logic       running,
  output wdtStb_t    stb,
  output regSel_t    sel,
  output logic [7:0] ctrlRd,
  output logic [7:0] stsCfgRd
);

  localparam int PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int MIN_W = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam logic [7:0] CNT_IDX  = countIdx(ALT_LAYOUT);
  localparam logic [7:0] CTRL_IDX = ctrlIdx(ALT_LAYOUT);

  logic [7:0]       idxQ;
  logic             minModeQ, kbdCtlEnQ, kbdRstEnQ;
  logic             mouseEnQ, kbdStsEnQ;
  logic             wrCount, wrCtrl, wrSts;
  logic             restart, secTick, minWrap;
  logic [PRE_W-1:0] preCnt;
  logic             activity;

  // index register and decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      idxQ <= 8'h00;
    else if (idxWr) idxQ <= wrData;
  end

  always_comb begin
    if (idxQ == CNT_IDX)       sel = SEL_COUNT;
    else if (idxQ == CTRL_IDX) sel = SEL_CTRL;
    else if (idxQ == IDX_STS)  sel = SEL_STS;
    else                       sel = SEL_NONE;
  end

  assign wrCount = dataWr && (sel == SEL_COUNT);
  assign wrCtrl  = dataWr && (sel == SEL_CTRL);
  assign wrSts   = dataWr && (sel == SEL_STS);

  // configuration bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minModeQ  <= 1'b0;
      kbdCtlEnQ <= 1'b0;
      kbdRstEnQ <= 1'b0;
      mouseEnQ  <= 1'b0;
      kbdStsEnQ <= 1'b0;
    end else begin
      if (wrCtrl) begin
        minModeQ  <= wrData[3];
        kbdCtlEnQ <= wrData[2];
        kbdRstEnQ <= wrData[1];
      end
      if (wrSts) begin
        mouseEnQ  <= wrData[7];
        kbdStsEnQ <= wrData[6];
      end
    end
  end

  assign ctrlRd   = {4'b0000, minModeQ, kbdCtlEnQ, kbdRstEnQ, 1'b0};
  assign stsCfgRd = {mouseEnQ, kbdStsEnQ, 6'b000000};

  assign activity = (kbdAct && (kbdCtlEnQ || kbdStsEnQ)) || (mouseAct && mouseEnQ);

  // timebase: restarts on any load, held while stopped
  assign restart = wrCount || stb.reload || !running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (restart || secTick) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  assign secTick = (preCnt == PRE_W'(CLKS_PER_SEC - 1));

  generate
    if (SECS_PER_MIN > 1) begin : g_minDiv
      logic [MIN_W-1:0] minCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        minCnt <= '0;
        else if (restart) minCnt <= '0;
        else if (secTick) minCnt <= minWrap ? '0 : minCnt + 1'b1;
      end
      assign minWrap = (minCnt == MIN_W'(SECS_PER_MIN - 1));
    end else begin : g_noMinDiv
      assign minWrap = 1'b1;
    end
  endgenerate

  always_comb begin
    stb           = '0;
    stb.loadCount = wrCount;
    stb.loadVal   = wrData;
    stb.reload    = running && !wrCount && activity;
    stb.unitTick  = !restart && secTick && (!minModeQ || minWrap);
    stb.clrFlag   = wrSts && !wrData[4];
    stb.kbdRstEn  = kbdRstEnQ;
  end

endmodule

// File: rtl/wdt_sec_dp.sv
module wdt_sec_dp
  import wdt_sec_pkg::*;
#(
  parameter int PULSE_CLKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStb_t          stb,
  output logic [CNT_W-1:0] countQ,
  output logic             flagQ,
  output logic             running,
  output logic             wdtOutN,
  output logic             kbdRstN
);

  localparam int PULSE_W = $clog2(PULSE_CLKS + 1);

  logic [CNT_W-1:0]   reloadValQ;
  logic [PULSE_W-1:0] pulseCnt;
  logic               kbdArmQ;
  logic               expire;

  assign running = (countQ != '0);
  assign expire  = !stb.loadCount && !stb.reload && stb.unitTick && (countQ == CNT_W'(1));

  // count register: write, then reload, then decrement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ     <= '0;
      reloadValQ <= '0;
    end else begin
      if (stb.loadCount) begin
        countQ <= stb.loadVal;
        if (stb.loadVal != '0) reloadValQ <= stb.loadVal;
      end else if (stb.reload) begin
        countQ <= reloadValQ;
      end else if (stb.unitTick && running) begin
        countQ <= countQ - 1'b1;
      end
    end
  end

  // timeout flag: expiry dominates a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (expire)      flagQ <= 1'b1;
    else if (stb.clrFlag) flagQ <= 1'b0;
  end

  // expiry pulse generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      kbdArmQ  <= 1'b0;
    end else if (expire) begin
      pulseCnt <= PULSE_W'(PULSE_CLKS);
      kbdArmQ  <= stb.kbdRstEn;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign wdtOutN = (pulseCnt == '0);
  assign kbdRstN = !((pulseCnt != '0) && kbdArmQ);

endmodule

// File: rtl/wdt_sec_top.sv
module wdt_sec_top
  import wdt_sec_pkg::*;
#(
  parameter int CLKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN = 60,
  parameter int PULSE_CLKS   = 16,
  parameter bit ALT_LAYOUT   = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       idxWr,
  input  logic       dataWr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       kbdAct,
  input  logic       mouseAct,
  output logic       wdtOutN,
  output logic       kbdRstN
);

  wdtStb_t          stb;
  regSel_t          sel;
  logic [7:0]       ctrlRd, stsCfgRd;
  logic [CNT_W-1:0] countQ;
  logic             flagQ, running;

  wdt_sec_ctrl #(
    .CLKS_PER_SEC(CLKS_PER_SEC),
    .SECS_PER_MIN(SECS_PER_MIN),
    .ALT_LAYOUT  (ALT_LAYOUT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr), .wrData(wrData),
    .kbdAct(kbdAct), .mouseAct(mouseAct), .running(running),
    .stb(stb), .sel(sel), .ctrlRd(ctrlRd), .stsCfgRd(stsCfgRd)
  );

  wdt_sec_dp #(
    .PULSE_CLKS(PULSE_CLKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .countQ(countQ), .flagQ(flagQ),
    .running(running), .wdtOutN(wdtOutN), .kbdRstN(kbdRstN)
  );

  always_comb begin
    unique case (sel)
      SEL_COUNT: rdData = countQ;
      SEL_CTRL:  rdData = ctrlRd;
      SEL_STS:   rdData = stsCfgRd | {3'b000, flagQ, 4'b0000};
      default:   rdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/wdt_sec_chk.sv
module wdt_sec_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wdtOutN,
  input logic       kbdRstN,
  input logic [7:0] countQ,
  input logic       flagQ,
  input logic       loadCount,
  input logic [7:0] loadVal,
  input logic       reload
);

  assert_stays_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == 8'd0 && !loadCount) |=> (countQ == 8'd0));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != 8'd0 && !loadCount && !reload) |=>
      (countQ == $past(countQ) || countQ == $past(countQ) - 8'd1));

  assert_pulse_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdtOutN) |-> ($past(countQ) == 8'd1 && countQ == 8'd0));

  assert_kbd_within_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    !kbdRstN |-> !wdtOutN);

  assert_flag_on_expiry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdtOutN) |-> flagQ);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadCount |=> (countQ == $past(loadVal)));

endmodule

bind wdt_sec_top wdt_sec_chk u_chk (
  .clk(clk), .rstN(rstN), .wdtOutN(wdtOutN), .kbdRstN(kbdRstN),
  .countQ(countQ), .flagQ(flagQ), .loadCount(stb.loadCount),
  .loadVal(stb.loadVal), .reload(stb.reload)
);

// File: tb/sim_wdt_sec_top.sv
`timescale 1ns/1ps
module sim_wdt_sec_top;

  localparam int CPS   = 4;
  localparam int PULSE = 3;
  localparam int SPM   = 60;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idxWr = 1'b0, dataWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       kbdAct = 1'b0, mouseAct = 1'b0;
  logic [7:0] rd0, rd1;
  logic       wdtN0, kbdN0, wdtN1, kbdN1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  wdt_sec_top #(.CLKS_PER_SEC(CPS), .SECS_PER_MIN(SPM), .PULSE_CLKS(PULSE), .ALT_LAYOUT(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr), .wrData(wrData),
    .rdData(rd0), .kbdAct(kbdAct), .mouseAct(mouseAct), .wdtOutN(wdtN0), .kbdRstN(kbdN0));

  wdt_sec_top #(.CLKS_PER_SEC(CPS), .SECS_PER_MIN(SPM), .PULSE_CLKS(PULSE), .ALT_LAYOUT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .idxWr(idxWr), .dataWr(dataWr), .wrData(wrData),
    .rdData(rd1), .kbdAct(kbdAct), .mouseAct(mouseAct), .wdtOutN(wdtN1), .kbdRstN(kbdN1));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIdx(input logic [7:0] idx);
    idxWr = 1'b1; wrData = idx;
    @(negedge clk);
    idxWr = 1'b0;
  endtask

  task automatic wrDat(input logic [7:0] val);
    dataWr = 1'b1; wrData = val;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  // returns at the negedge right after the data write edge
  task automatic wrReg(input logic [7:0] idx, input logic [7:0] val);
    setIdx(idx);
    wrDat(val);
  endtask

  task automatic pulseKbd();
    kbdAct = 1'b1; @(negedge clk); kbdAct = 1'b0;
  endtask

  task automatic pulseMouse();
    mouseAct = 1'b1; @(negedge clk); mouseAct = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdData idx0", rd0, 0);
    chk("R1 wdtOutN", wdtN0, 1);
    chk("R1 kbdRstN", kbdN0, 1);
    setIdx(8'hF6); chk("R1 count", rd0, 0);
    setIdx(8'hF7); chk("R1 status", rd0, 0);
  endtask

  task automatic t_countdown();
    wrReg(8'hF5, 8'h00);
    wrReg(8'hF6, 8'd3);
    chk("R2 load", rd0, 3);
    waitEdges(CPS - 1); chk("R2 before tick", rd0, 3);
    waitEdges(1);       chk("R2 first tick", rd0, 2);
    waitEdges(2*CPS-1); chk("R4 pre-expiry out", wdtN0, 1);
    chk("R2 last unit", rd0, 1);
    waitEdges(1);
    chk("R4 out low", wdtN0, 0);
    chk("R4 count zero", rd0, 0);
    chk("R5 kbd idle when disabled", kbdN0, 1);
    waitEdges(PULSE - 1); chk("R4 still low", wdtN0, 0);
    waitEdges(1);         chk("R4 pulse end", wdtN0, 1);
    setIdx(8'hF7); chk("R6 flag set", rd0, 8'h10);
    wrDat(8'h10);  chk("R6 write 1 keeps", rd0, 8'h10);
    wrDat(8'h00);  chk("R6 flag cleared", rd0, 8'h00);
  endtask

  task automatic t_kbdReset();
    wrReg(8'hF5, 8'h02);
    wrReg(8'hF6, 8'd1);
    waitEdges(CPS - 1); chk("R5 kbd before", kbdN0, 1);
    waitEdges(1);
    chk("R5 kbd low", kbdN0, 0);
    chk("R5 wdt low", wdtN0, 0);
    waitEdges(PULSE); chk("R5 kbd end", kbdN0, 1);
    wrReg(8'hF5, 8'h00);
    wrReg(8'hF7, 8'h00);
  endtask

  task automatic t_stop();
    int bad = 0;
    wrReg(8'hF6, 8'd5);
    waitEdges(2);
    wrDat(8'h00);
    chk("R3 stopped", rd0, 0);
    for (int i = 0; i < 12*CPS; i++) begin
      if (wdtN0 !== 1'b1) bad++;
      pulseKbd();
    end
    chk("R3 no pulse", bad, 0);
    chk("R3 still zero", rd0, 0);
    setIdx(8'hF7); chk("R3 no flag", rd0, 0);
  endtask

  task automatic t_minute();
    wrReg(8'hF5, 8'h08);
    setIdx(8'hF5); chk("R7 ctrl readback", rd0, 8'h08);
    wrReg(8'hF6, 8'd2);
    waitEdges(SPM*CPS - 1); chk("R7 before minute", rd0, 2);
    waitEdges(1);           chk("R7 after minute", rd0, 1);
    wrDat(8'h00);
    wrReg(8'hF5, 8'h00);
  endtask

  task automatic t_kbd();
    wrReg(8'hF5, 8'h04);
    wrReg(8'hF6, 8'd2);
    waitEdges(CPS + 1); chk("R8 decremented", rd0, 1);
    pulseKbd();         chk("R8 reloaded", rd0, 2);
    waitEdges(CPS - 1); chk("R8 full unit after reload", rd0, 2);
    waitEdges(1);       chk("R8 tick after reload", rd0, 1);
    wrReg(8'hF5, 8'h00);
    wrReg(8'hF6, 8'd2);
    waitEdges(CPS + 1);
    pulseKbd();         chk("R8 ignored when disabled", rd0, 1);
    wrDat(8'h00);
    // status bit 6 path
    wrReg(8'hF7, 8'h40);
    wrReg(8'hF6, 8'd2);
    waitEdges(CPS + 1);
    pulseKbd();         chk("R8 status enable reload", rd0, 2);
    wrDat(8'h00);
    wrReg(8'hF7, 8'h00);
  endtask

  task automatic t_mouse();
    wrReg(8'hF6, 8'd2);
    waitEdges(CPS + 1);
    pulseMouse();       chk("R9 ignored when disabled", rd0, 1);
    wrDat(8'h00);
    wrReg(8'hF7, 8'h80);
    wrReg(8'hF6, 8'd2);
    waitEdges(CPS + 1); chk("R9 decremented", rd0, 1);
    pulseMouse();       chk("R9 reloaded", rd0, 2);
    wrDat(8'h00);
    setIdx(8'hF7); chk("R9 enable readback", rd0, 8'h80);
    wrDat(8'h00);
  endtask

  task automatic t_priority();
    wrReg(8'hF6, 8'd3);
    waitEdges(CPS - 1);
    wrDat(8'd7);        chk("R10 write beats tick", rd0, 7);
    waitEdges(CPS - 1); chk("R12 full unit after rewrite", rd0, 7);
    waitEdges(1);       chk("R12 tick from new value", rd0, 6);
    wrDat(8'h00);
  endtask

  task automatic t_map();
    setIdx(8'h30); wrDat(8'h55);
    chk("R11 unmapped reads 0", rd0, 0);
    wrReg(8'hF5, 8'hFF);
    chk("R11 ctrl bits 3:1 only", rd0, 8'h0E);
    chk("R11 alt ignores 0xF5", rd1, 0);
    wrDat(8'h00);
    wrReg(8'hF4, 8'd9);
    chk("R11 alt count", rd1, 9);
    chk("R11 default ignores 0xF4", rd0, 0);
    wrDat(8'h00);
    wrReg(8'hF3, 8'h0A);
    chk("R11 alt ctrl", rd1, 8'h0A);
    wrDat(8'h00);
  endtask

  initial begin
    waitEdges(3);
    rstN = 1'b1;
    waitEdges(1);
    t_reset();
    t_countdown();
    t_kbdReset();
    t_stop();
    t_minute();
    t_kbd();
    t_mouse();
    t_priority();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule